// File: doc/BRIEF.md
# Register Bus Address Decoder with Memory Window

This block is the front end between a single-beat request/response bus and a bank of 32-bit registers plus one memory window. Each accepted request is decoded into a one-hot register write strobe, a one-hot register read strobe and a read-data selection. Requests that fall inside the window's range go out on a secondary window port. The block also forms every error response.

Registers are laid out at 4-byte steps from offset zero in the order of their index. A parameter can leave reserved slots after the low group. The window follows at the next offset aligned to its power-of-two size. A high group of registers starts right after the window's last byte.

With default parameters there are four low registers and one reserved slot, so the next free offset is 0x14. An eight-word window therefore lands at 0x20..0x3F, and the two high registers sit at 0x40 and 0x44. A development-mode input selects what happens on an unmapped access: it either returns an error or fails silently.

Top module: `regbus_decode_top`

## Requirements
- R1: Register indices 0..3 decode at byte offsets 0x0, 0x4, 0x8 and 0xC. The address bits [1:0] are ignored for register decode. The reserved slot 0x10 and the range 0x14..0x1F match nothing.
- R2: The 32-byte window is placed at the size-aligned base 0x20 and covers 0x20..0x3F. A request in that range asserts `win_req_valid_o` in its accept cycle, with `win_addr_o` = address − 0x20, `win_we_o` = 1 for writes, and the write data on `win_wdata_o`.
- R3: Register indices 4 and 5 decode at 0x40 and 0x44, directly after the window. Offsets from 0x48 upward are unmapped.
- R4: A write (opcode 0 full, opcode 1 partial) of size code 2 (4 bytes) to a register raises only that register's `reg_we_o` bit, in the accept cycle, with the data on `reg_wdata_o`. The response has no error and zero data.
- R5: A read (opcode 4) raises only the matching `reg_re_o` bit, in the accept cycle. The response carries the word presented on `reg_rdata_i` in that cycle and is valid on the next cycle.
- R6: A read of size code 0 or 1 returns the full 32-bit register word without error.
- R7: A register write with a size code other than 2 raises no write strobe and returns an error.
- R8: When `dev_mode_i` is 1, a legal-opcode access that matches no register or window returns an error and raises no strobe.
- R9: When `dev_mode_i` is 0, such an unmapped write is dropped without error. Such an unmapped read returns 0xFFFFFFFF without error.
- R10: Opcodes other than 0, 1 and 4 return an error in every mode. They raise no register strobe and are not forwarded to the window.
- R11: A window response (`win_rsp_valid_i`) is returned unchanged in data and error on the cycle after it arrives.
- R12: Only one request is outstanding. `req_ready_o` is low from acceptance until the response handshake completes. The response stays valid with stable data and error until `rsp_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_mode_i | input | 1 | 1: unmapped accesses return an error; 0: they fail silently |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_opcode_i | input | 3 | 0 full write, 1 partial write, 4 read, others illegal |
| req_addr_i | input | AW (12) | Byte address |
| req_size_i | input | 2 | log2 of access size in bytes |
| req_wdata_i | input | DW (32) | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_rdata_o | output | DW (32) | Response data |
| rsp_err_o | output | 1 | Response error flag |
| reg_we_o | output | NREG (6) | One-hot register write strobes |
| reg_re_o | output | NREG (6) | One-hot register read strobes |
| reg_wdata_o | output | DW (32) | Register write data |
| reg_rdata_i | input | NREG*DW (192) | Register contents, register i in bits [i*32 +: 32] |
| win_req_valid_o | output | 1 | Window request pulse |
| win_we_o | output | 1 | Window request is a write |
| win_addr_o | output | WOW (5) | Byte offset inside the window |
| win_wdata_o | output | DW (32) | Window write data |
| win_rsp_valid_i | input | 1 | Window response valid |
| win_rdata_i | input | DW (32) | Window response data |
| win_err_i | input | 1 | Window response error |

## Verification
The strobes `reg_we_o`, `reg_re_o` and `win_req_valid_o` are combinational in the accept cycle, so the bench drives a request after a falling edge and samples them before the next rising edge. A register, unmapped or illegal-opcode response is due one edge after acceptance. The bench checks it at the following falling edge, after changing `reg_rdata_i` to confirm the accept-cycle value was captured. A window response is due one edge after `win_rsp_valid_i`, which the bench delays by a random number of cycles while checking that no response appears early. The bench then holds `rsp_ready_i` low for several cycles and confirms at each falling edge that the response stays valid and unchanged.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_PUT_PART = 3'd1;
  localparam logic [2:0] OP_GET      = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_WIN, ST_RSP} state_e;

  function automatic int unsigned align_up(int unsigned off, int unsigned sz);
    return ((off + sz - 1) / sz) * sz;
  endfunction
endpackage

// File: rtl/regbus_addr_decode.sv
module regbus_addr_decode #(
  parameter int unsigned AW       = 12,
  parameter int unsigned BPW      = 4,
  parameter int unsigned LO_REGS  = 4,
  parameter int unsigned HI_REGS  = 2,
  parameter int unsigned WIN_BASE = 32,
  parameter int unsigned WIN_OW   = 5,
  parameter int unsigned HI_BASE  = 64,
  localparam int unsigned NREG    = LO_REGS + HI_REGS,
  localparam int unsigned AL      = $clog2(BPW)
) (
  input  logic [AW-1:0]     addr_i,
  output logic [NREG-1:0]   reg_hit_o,
  output logic              win_hit_o,
  output logic [WIN_OW-1:0] win_off_o
);
  localparam logic [AW-1:0] WIN_BASE_A = AW'(WIN_BASE);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int unsigned OFF = (i < LO_REGS) ? i * BPW : HI_BASE + (i - LO_REGS) * BPW;
    localparam logic [AW-1:0] OFF_A = AW'(OFF);
    assign reg_hit_o[i] = (addr_i[AW-1:AL] == OFF_A[AW-1:AL]);
  end

  assign win_hit_o = (addr_i[AW-1:WIN_OW] == WIN_BASE_A[AW-1:WIN_OW]);
  assign win_off_o = addr_i[WIN_OW-1:0];
endmodule

// File: rtl/regbus_rdata_mux.sv
module regbus_rdata_mux #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 6
) (
  input  logic [NREG-1:0]    sel_i,
  input  logic [NREG*DW-1:0] rdata_i,
  output logic [DW-1:0]      rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel_i[i]) rdata_o = rdata_o | rdata_i[i*DW +: DW];
    end
  end
endmodule

// File: rtl/regbus_rsp_hold.sv
module regbus_rsp_hold #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          err_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      err_o   <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      err_o   <= err_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_rsp_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(err_o));
endmodule

// File: rtl/regbus_decode_top.sv
module regbus_decode_top
  import regbus_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned DW         = 32,
  parameter int unsigned LO_REGS    = 4,
  parameter int unsigned RSVD_SLOTS = 1,
  parameter int unsigned WIN_ITEMS  = 8,
  parameter int unsigned HI_REGS    = 2,
  localparam int unsigned NREG      = LO_REGS + HI_REGS,
  localparam int unsigned BPW       = DW / 8,
  localparam int unsigned WIN_BYTES = WIN_ITEMS * BPW,
  localparam int unsigned WOW       = $clog2(WIN_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_opcode_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              rsp_err_o,
  output logic [NREG-1:0]   reg_we_o,
  output logic [NREG-1:0]   reg_re_o,
  output logic [DW-1:0]     reg_wdata_o,
  input  logic [NREG*DW-1:0] reg_rdata_i,
  output logic              win_req_valid_o,
  output logic              win_we_o,
  output logic [WOW-1:0]    win_addr_o,
  output logic [DW-1:0]     win_wdata_o,
  input  logic              win_rsp_valid_i,
  input  logic [DW-1:0]     win_rdata_i,
  input  logic              win_err_i
);
  localparam int unsigned WIN_BASE  = align_up((LO_REGS + RSVD_SLOTS) * BPW, WIN_BYTES);
  localparam int unsigned HI_BASE   = WIN_BASE + WIN_BYTES;
  localparam logic [1:0]  FULL_SIZE = 2'($clog2(BPW));

  state_e          state_q, state_d;
  logic [NREG-1:0] reg_hit;
  logic            win_hit, any_reg, miss;
  logic [WOW-1:0]  win_off;
  logic            accept, is_get, is_put, op_bad, size_bad, fwd;
  logic [DW-1:0]   mux_rdata, ld_data;
  logic            ld, ld_err;

  regbus_addr_decode #(
    .AW(AW), .BPW(BPW), .LO_REGS(LO_REGS), .HI_REGS(HI_REGS),
    .WIN_BASE(WIN_BASE), .WIN_OW(WOW), .HI_BASE(HI_BASE)
  ) i_decode (
    .addr_i(req_addr_i), .reg_hit_o(reg_hit), .win_hit_o(win_hit), .win_off_o(win_off)
  );

  regbus_rdata_mux #(.DW(DW), .NREG(NREG)) i_mux (
    .sel_i(reg_hit), .rdata_i(reg_rdata_i), .rdata_o(mux_rdata)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign is_get      = (req_opcode_i == OP_GET);
  assign is_put      = (req_opcode_i == OP_PUT_FULL) || (req_opcode_i == OP_PUT_PART);
  assign op_bad      = !(is_get || is_put);
  assign any_reg     = |reg_hit;
  assign miss        = !any_reg && !win_hit;
  assign size_bad    = is_put && any_reg && (req_size_i != FULL_SIZE);
  assign fwd         = win_hit && !op_bad;

  assign reg_we_o    = (accept && is_put && !size_bad) ? reg_hit : '0;
  assign reg_re_o    = (accept && is_get) ? reg_hit : '0;
  assign reg_wdata_o = req_wdata_i;

  assign win_req_valid_o = accept && fwd;
  assign win_we_o        = is_put;
  assign win_addr_o      = win_off;
  assign win_wdata_o     = req_wdata_i;

  // local response contents for the accept cycle, window response otherwise
  always_comb begin
    ld      = 1'b0;
    ld_data = '0;
    ld_err  = 1'b0;
    if (state_q == ST_WIN) begin
      ld      = win_rsp_valid_i;
      ld_data = win_rdata_i;
      ld_err  = win_err_i;
    end else if (accept && !fwd) begin
      ld = 1'b1;
      if (op_bad) begin
        ld_err = 1'b1;
      end else if (miss) begin
        ld_data = '1;
        ld_err  = dev_mode_i;
      end else begin
        ld_data = is_get ? mux_rdata : '0;
        ld_err  = size_bad;
      end
    end
  end

  regbus_rsp_hold #(.DW(DW)) i_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld), .data_i(ld_data), .err_i(ld_err),
    .ready_i(rsp_ready_i), .valid_o(rsp_valid_o), .data_o(rsp_rdata_o), .err_o(rsp_err_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = fwd ? ST_WIN : ST_RSP;
      ST_WIN:  if (win_rsp_valid_i) state_d = ST_RSP;
      ST_RSP:  if (rsp_valid_o && rsp_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assert_one_read_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|reg_re_o) |-> $onehot(reg_re_o) && (reg_we_o == '0) && !win_req_valid_o);
  assert_local_rsp_next_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !fwd |=> rsp_valid_o);
  assert_illegal_op_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && op_bad |=> rsp_valid_o && rsp_err_o);
  assert_quiet_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && miss && !op_bad && !dev_mode_i |=> rsp_valid_o && !rsp_err_o);
  assert_win_pass_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WIN) && win_rsp_valid_i |=>
      rsp_valid_o && (rsp_err_o == $past(win_err_i)) && (rsp_rdata_o == $past(win_rdata_i)));
  assert_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
endmodule

// File: tb/test_regbus_decode_top.sv
module test_regbus_decode_top;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned NREG = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_mode = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [11:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NREG-1:0] reg_we, reg_re;
  logic [31:0] reg_wdata;
  logic [NREG*32-1:0] reg_rdata = '0;
  logic win_req_valid, win_we;
  logic [4:0] win_addr;
  logic [31:0] win_wdata;
  logic win_rsp_valid = 1'b0, win_err = 1'b0;
  logic [31:0] win_rdata = '0;

  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  regbus_decode_top i_regbus_decode_top (
    .clk_i(clk), .rst_ni(rst_n), .dev_mode_i(dev_mode),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_opcode_i(req_op),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
    .win_req_valid_o(win_req_valid), .win_we_o(win_we), .win_addr_o(win_addr),
    .win_wdata_o(win_wdata), .win_rsp_valid_i(win_rsp_valid), .win_rdata_i(win_rdata),
    .win_err_i(win_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // 0..5 register index, 6 window, 7 unmapped
  function automatic int classify(input logic [11:0] a);
    logic [11:0] w = {a[11:2], 2'b00};
    if (w == 12'h000) return 0;
    if (w == 12'h004) return 1;
    if (w == 12'h008) return 2;
    if (w == 12'h00C) return 3;
    if (w == 12'h040) return 4;
    if (w == 12'h044) return 5;
    if (a >= 12'h020 && a <= 12'h03F) return 6;
    return 7;
  endfunction

  function automatic string req_of(input int cls);
    if (cls <= 3) return "R1";
    if (cls <= 5) return "R3";
    if (cls == 6) return "R2";
    return "R8";
  endfunction

  task automatic run(input logic [2:0] op, input logic [11:0] addr, input logic [1:0] size,
                     input logic [31:0] wd, input bit dev, input int hold, input int wdly,
                     input logic [31:0] wrd, input bit werr);
    int cls = classify(addr);
    bit legal = (op == 3'd0) || (op == 3'd1) || (op == 3'd4);
    bit put = (op == 3'd0) || (op == 3'd1);
    bit get = (op == 3'd4);
    logic [NREG-1:0] exp_we = '0, exp_re = '0;
    bit exp_win = legal && (cls == 6);
    logic [31:0] exp_d = '0, old_rd = '0;
    bit exp_e = 1'b0, chk_d = 1'b1;
    string rq = req_of(cls);
    @(negedge clk);
    for (int i = 0; i < NREG; i++) reg_rdata[i*32 +: 32] = $urandom;
    req_valid = 1'b1; req_op = op; req_addr = addr; req_size = size; req_wdata = wd; dev_mode = dev;
    #1;
    if (legal && put && cls < 6 && size == 2'd2) exp_we[cls] = 1'b1;
    if (get && cls < 6) exp_re[cls] = 1'b1;
    if (cls < 6) old_rd = reg_rdata[cls*32 +: 32];
    check(req_ready == 1'b1, "R12 ready idle", 64'(req_ready), 64'd1);
    check(reg_we == exp_we, put ? (size == 2'd2 ? "R4 we" : "R7 we") : (legal ? rq : "R10"), 64'(reg_we), 64'(exp_we));
    check(reg_re == exp_re, legal ? "R5 re" : "R10 re", 64'(reg_re), 64'(exp_re));
    check(win_req_valid == exp_win, legal ? "R2 win req" : "R10 win", 64'(win_req_valid), 64'(exp_win));
    if (exp_we != '0) check(reg_wdata == wd, "R4 wdata", 64'(reg_wdata), 64'(wd));
    if (exp_win) begin
      check(win_addr == 5'(addr - 12'h020), "R2 win addr", 64'(win_addr), 64'(5'(addr - 12'h020)));
      check(win_we == put, "R2 win we", 64'(win_we), 64'(put));
      if (put) check(win_wdata == wd, "R2 win wdata", 64'(win_wdata), 64'(wd));
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < NREG; i++) reg_rdata[i*32 +: 32] = $urandom;
    check(req_ready == 1'b0, "R12 busy", 64'(req_ready), 64'd0);
    if (exp_win) begin
      for (int k = 0; k < wdly; k++) begin
        check(rsp_valid == 1'b0, "R11 early", 64'(rsp_valid), 64'd0);
        @(negedge clk);
      end
      check(rsp_valid == 1'b0, "R11 early", 64'(rsp_valid), 64'd0);
      win_rsp_valid = 1'b1; win_rdata = wrd; win_err = werr;
      @(posedge clk);
      @(negedge clk);
      win_rsp_valid = 1'b0; win_rdata = $urandom; win_err = 1'b0;
      exp_d = wrd; exp_e = werr; rq = "R11";
    end else if (!legal) begin
      exp_e = 1'b1; chk_d = 1'b0; rq = "R10";
    end else if (cls < 6) begin
      if (put) begin
        exp_e = (size != 2'd2); chk_d = !exp_e; rq = exp_e ? "R7" : "R4";
      end else begin
        exp_d = old_rd; rq = (size == 2'd2) ? "R5" : "R6";
      end
    end else begin
      exp_e = dev; chk_d = !dev; exp_d = 32'hFFFF_FFFF; rq = dev ? "R8" : "R9";
    end
    check(rsp_valid == 1'b1, {rq, " rsp valid"}, 64'(rsp_valid), 64'd1);
    check(rsp_err == exp_e, {rq, " rsp err"}, 64'(rsp_err), 64'(exp_e));
    if (chk_d) check(rsp_rdata == exp_d, {rq, " rsp data"}, 64'(rsp_rdata), 64'(exp_d));
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_err == exp_e && (!chk_d || rsp_rdata == exp_d) && !req_ready,
            "R12 hold", {31'd0, rsp_valid, rsp_rdata}, {31'd0, 1'b1, exp_d});
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R12 release", 64'({rsp_valid, req_ready}), 64'b01);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && reg_we == '0 && reg_re == '0 && !win_req_valid,
          "R12 reset state", 64'({rsp_valid, reg_we, reg_re}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R12 ready after reset", 64'(req_ready), 64'd1);

    // directed corners
    run(3'd0, 12'h000, 2'd2, 32'h1234_5678, 1, 0, 0, 0, 0);  // R4 R1
    run(3'd4, 12'h00C, 2'd2, 0, 1, 2, 0, 0, 0);               // R5 R1
    run(3'd4, 12'h003, 2'd0, 0, 1, 0, 0, 0, 0);               // R6 byte read
    run(3'd4, 12'h046, 2'd1, 0, 0, 1, 0, 0, 0);               // R6 R3
    run(3'd1, 12'h004, 2'd1, 32'hAA, 1, 0, 0, 0, 0);          // R7
    run(3'd0, 12'h010, 2'd2, 32'h5, 1, 0, 0, 0, 0);           // R1 reserved, R8
    run(3'd0, 12'h010, 2'd2, 32'h5, 0, 0, 0, 0, 0);           // R9 write
    run(3'd4, 12'h01F, 2'd2, 0, 0, 0, 0, 0, 0);               // R9 read
    run(3'd4, 12'h048, 2'd2, 0, 1, 0, 0, 0, 0);               // R3 end, R8
    run(3'd4, 12'h020, 2'd2, 0, 1, 0, 2, 32'hCAFE_0001, 0);   // R2 base
    run(3'd0, 12'h03F, 2'd2, 32'h77, 0, 0, 0, 32'h0, 1);      // R2 last, R11 err
    run(3'd7, 12'h024, 2'd2, 0, 0, 0, 0, 0, 0);               // R10 window
    run(3'd2, 12'h008, 2'd2, 0, 0, 0, 0, 0, 0);               // R10 register
    run(3'd5, 12'h050, 2'd2, 0, 0, 0, 0, 0, 0);               // R10 unmapped

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      logic [11:0] a;
      int r = $urandom_range(0, 9);
      op = (r < 4) ? 3'd4 : (r < 7) ? 3'd0 : (r < 8) ? 3'd1 : 3'($urandom_range(2, 7));
      if (op == 3'd4 || op == 3'd0 || op == 3'd1) op = op; else if (op == 3'd4) op = 3'd4;
      a = 12'($urandom_range(0, 95));
      run(op, a, 2'($urandom_range(0, 3)), $urandom, 1'($urandom_range(0, 1)),
          $urandom_range(0, 3), $urandom_range(0, 4), $urandom, 1'($urandom_range(0, 1)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule